// File: doc/BRIEF.md
# Synchronous Burst SRAM Core with Byte Writes

This block is a synthesizable model of a small synchronous static RAM: 256 words of 32 bits by default, split into four byte lanes. Address, write data and control are all sampled on the rising clock edge. An access either loads a fresh address, or continues from the previous address through an internal burst counter. That counter walks a four-word block in interleaved order by default, or in linear order when a parameter selects it. Writes go to the selected lanes only, or to every lane under a global write.

The read path is chosen at run time by a mode input. In flow-through mode the addressed word reaches the output in the cycle right after the capturing edge. In pipelined mode it passes through one more output register and appears a cycle later. A deselect takes effect one stage earlier than a pipelined read: the output stops being driven in the cycle right after the edge that captures it. An asynchronous output enable and a sleep input also gate the output. Sleep also blocks every access, ends any burst and leaves the stored words untouched.

Top module: `sbs_sram`

## Requirements
- R1: On a load, the block is selected only when `ce_a` is 1, `ce_b` is 1 and `ce_c_n` is 0. A load with any of these inactive is a deselect.
- R2: A byte write happens when `byte_wr_en` is 1 and at least one `byte_sel` bit is 1. Only the lanes whose bit is 1 change, where bit i covers data bits 8i+7..8i.
- R3: With `all_wr` at 0, a command with `byte_wr_en` at 0, or with `byte_wr_en` at 1 and `byte_sel` all zero, is a read and leaves memory unchanged.
- R4: `all_wr` at 1 writes all four lanes, whatever `byte_sel` and `byte_wr_en` hold.
- R5: With `pipe_mode` at 0, a read captured at clock edge k drives its word on `rdata` with `rdata_drive` at 1 in the cycle after edge k.
- R6: With `pipe_mode` at 1, a read captured at edge k is driven in the cycle after edge k+1, and not in the cycle after edge k.
- R7: A deselect captured at edge k turns `rdata_drive` off in the cycle after edge k, in both modes. In pipelined mode this also holds back a read that would otherwise arrive in that cycle.
- R8: With `cmd_load` at 0 and a burst active, `cmd_adv` at 1 steps a 2-bit counter c. The address is the loaded address with its two low bits XORed with c, so it wraps inside its four-word block. With `cmd_adv` at 0 the same address is accessed again.
- R9: A write completes at the edge that captures it, so a read of the same address at the next edge returns the new data.
- R10: `out_en` at 0 forces `rdata_drive` and `rdata` to 0 at once, without waiting for a clock edge.
- R11: While `sleep` is 1, commands are ignored (no write takes place), the output is not driven, and the active burst ends. Stored contents are kept.
- R12: After reset the block is deselected, with `rdata_drive` and `rdata` at 0. Whenever `rdata_drive` is 0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Start an access at `addr` |
| cmd_adv | input | 1 | Step the burst counter on a continuing access |
| addr | input | 8 | Word address for a load |
| wdata | input | 32 | Write data |
| byte_sel | input | 4 | Per-lane write selects |
| byte_wr_en | input | 1 | Enables the lane selects |
| all_wr | input | 1 | Write all lanes |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| pipe_mode | input | 1 | 1 selects the registered read path, 0 selects flow-through |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Halts accesses and turns the output off |
| rdata | output | 32 | Read data, 0 when not driven |
| rdata_drive | output | 1 | High while `rdata` carries valid read data |

## Verification
The sharpest collision is a pipelined read that is due on the output in the very cycle a deselect is captured. The bench provokes it by loading a read in pipelined mode and then issuing a load with one chip enable inactive on the next edge. It judges the result by `rdata_drive` being low in the following cycle. A second overlap, a write and a read of the same word on consecutive edges, comes up throughout the vector table: every write is read back on the next edge and compared with a reference memory kept in the bench.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
    parameter int ADDR_W       = 8,
    parameter int BURST_W      = 2,
    parameter bit LINEAR_ORDER = 1'b0
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] step,
    output logic [ADDR_W-1:0]  acc_addr
);
    logic [BURST_W-1:0] low_bits;

    generate
        if (LINEAR_ORDER) begin : g_linear
            assign low_bits = base[BURST_W-1:0] + step;
        end else begin : g_interleave
            assign low_bits = base[BURST_W-1:0] ^ step;
        end
    endgenerate

    assign acc_addr = {base[ADDR_W-1:BURST_W], low_bits};
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [LANES-1:0]   wr_mask,
    input  logic [LANES*8-1:0] wr_word,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [LANES*8-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            logic [7:0] store [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && wr_mask[ln]) begin
                    store[wr_addr] <= wr_word[ln*8 +: 8];
                end
            end

            assign rd_word[ln*8 +: 8] = store[rd_addr];
        end
    endgenerate
endmodule

// File: rtl/sbs_out_path.sv
module sbs_out_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_idle,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              pipe_mode,
    input  logic              out_en,
    input  logic              sleep,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] word;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  drive_int;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.vld  = acc_rd;
        pipe_d.word = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        if (pipe_mode) begin
            drive_int = pipe_q.vld && !acc_idle;
        end else begin
            drive_int = acc_rd;
        end
        rdata_drive = drive_int && out_en && !sleep;
        if (!rdata_drive) begin
            rdata = '0;
        end else if (pipe_mode) begin
            rdata = pipe_q.word;
        end else begin
            rdata = rd_word;
        end
    end

    // R10
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!rdata_drive && rdata == '0));
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int BURST_W      = 2,
    parameter bit LINEAR_ORDER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic              cmd_adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] byte_sel,
    input  logic              byte_wr_en,
    input  logic              all_wr,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              pipe_mode,
    input  logic              out_en,
    input  logic              sleep,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);
    import sbs_pkg::*;

    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] step;
        logic               active;
        acc_kind_e          kind;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [ADDR_W-1:0] acc_addr_d, acc_addr_q;
    logic              selected;
    logic              wr_req;
    logic [LANES-1:0]  wr_mask;
    logic [DATA_W-1:0] rd_word;

    assign selected = ce_a && ce_b && !ce_c_n;
    assign wr_req   = all_wr || (byte_wr_en && (|byte_sel));
    assign wr_mask  = all_wr ? {LANES{1'b1}} : byte_sel;

    always_comb begin
        ctl_d = ctl_q;
        if (sleep) begin
            ctl_d.active = 1'b0;
            ctl_d.kind   = ACC_IDLE;
        end else if (cmd_load) begin
            if (selected) begin
                ctl_d.base   = addr;
                ctl_d.step   = '0;
                ctl_d.active = 1'b1;
                ctl_d.kind   = wr_req ? ACC_WR : ACC_RD;
            end else begin
                ctl_d.active = 1'b0;
                ctl_d.kind   = ACC_IDLE;
            end
        end else if (ctl_q.active) begin
            ctl_d.step = ctl_q.step + BURST_W'(cmd_adv);
            ctl_d.kind = wr_req ? ACC_WR : ACC_RD;
        end else begin
            ctl_d.kind = ACC_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '{base: '0, step: '0, active: 1'b0, kind: ACC_IDLE};
            acc_addr_q <= '0;
        end else begin
            ctl_q      <= ctl_d;
            acc_addr_q <= acc_addr_d;
        end
    end

    sbs_burst_gen #(
        .ADDR_W      (ADDR_W),
        .BURST_W     (BURST_W),
        .LINEAR_ORDER(LINEAR_ORDER)
    ) u_burst (
        .base    (ctl_d.base),
        .step    (ctl_d.step),
        .acc_addr(acc_addr_d)
    );

    sbs_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES)
    ) u_array (
        .clk    (clk),
        .wr_en  (ctl_d.kind == ACC_WR),
        .wr_addr(acc_addr_d),
        .wr_mask(wr_mask),
        .wr_word(wdata),
        .rd_addr(acc_addr_q),
        .rd_word(rd_word)
    );

    sbs_out_path #(
        .DATA_W(DATA_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_rd     (ctl_q.kind == ACC_RD),
        .acc_idle   (ctl_q.kind == ACC_IDLE),
        .rd_word    (rd_word),
        .pipe_mode  (pipe_mode),
        .out_en     (out_en),
        .sleep      (sleep),
        .rdata      (rdata),
        .rdata_drive(rdata_drive)
    );

    // R7
    desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !selected && !sleep) |=> !rdata_drive);

    // R5
    flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && selected && !wr_req && !sleep && !pipe_mode)
        |=> (pipe_mode || !out_en || sleep || rdata_drive));

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_drive);

    // R11
    sleep_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !cmd_load) |=> (!cmd_load |-> !rdata_drive));

    // R12
    quiet_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_drive |-> (rdata == '0));
endmodule

// File: tb/sbs_sram_tb.sv
`timescale 1ns/1ps
module sbs_sram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_load = 1'b0, cmd_adv = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  byte_sel = '0;
    logic        byte_wr_en = 1'b0, all_wr = 1'b0;
    logic        ce_a = 1'b1, ce_b = 1'b1, ce_c_n = 1'b0;
    logic        pipe_mode = 1'b0, out_en = 1'b1, sleep = 1'b0;
    logic [31:0] rdata;
    logic        rdata_drive;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] model [256];

    always #2.5 clk = ~clk;

    sbs_sram u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_adv(cmd_adv),
        .addr(addr), .wdata(wdata), .byte_sel(byte_sel), .byte_wr_en(byte_wr_en),
        .all_wr(all_wr), .ce_a(ce_a), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .pipe_mode(pipe_mode), .out_en(out_en), .sleep(sleep),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    // {addr, data, byte_sel, byte_wr_en, all_wr}
    localparam logic [45:0] VEC [8] = '{
        {8'd10,  32'h11223344, 4'b0000, 1'b0, 1'b1},
        {8'd10,  32'hAABBCCDD, 4'b0101, 1'b1, 1'b0},
        {8'd10,  32'h55555555, 4'b1111, 1'b0, 1'b0},
        {8'd10,  32'h66666666, 4'b0000, 1'b1, 1'b0},
        {8'd10,  32'h99999999, 4'b0011, 1'b1, 1'b1},
        {8'd20,  32'h01020304, 4'b0000, 1'b0, 1'b1},
        {8'd20,  32'hF0F0F0F0, 4'b1000, 1'b1, 1'b0},
        {8'd255, 32'hDEADBEEF, 4'b0000, 1'b0, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet_cmd();
        cmd_load = 1'b0; cmd_adv = 1'b0;
        byte_sel = '0; byte_wr_en = 1'b0; all_wr = 1'b0;
    endtask

    task automatic wr_full(input logic [7:0] a, input logic [31:0] d);
        cmd_load = 1'b1; addr = a; wdata = d; all_wr = 1'b1;
        tick();
        model[a] = d;
        quiet_cmd();
    endtask

    task automatic deselect();
        cmd_load = 1'b1; ce_a = 1'b0;
        tick();
        ce_a = 1'b1; quiet_cmd();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12: reset state
        chk("R12 drive after reset", {31'd0, rdata_drive}, 32'd0);
        chk("R12 data after reset", rdata, 32'd0);

        // table walk: write command, then flow-through read of the same word
        for (int i = 0; i < 8; i++) begin
            logic [7:0]  va;
            logic [31:0] vd;
            logic [3:0]  vb;
            logic        vbw, vg;
            {va, vd, vb, vbw, vg} = VEC[i];
            cmd_load = 1'b1; addr = va; wdata = vd;
            byte_sel = vb; byte_wr_en = vbw; all_wr = vg;
            tick();
            if (vg) begin
                model[va] = vd;
            end else if (vbw && (|vb)) begin
                for (int ln = 0; ln < 4; ln++) begin
                    if (vb[ln]) model[va][ln*8 +: 8] = vd[ln*8 +: 8];
                end
            end
            byte_sel = '0; byte_wr_en = 1'b0; all_wr = 1'b0;
            tick();
            // R2 R3 R4 R9 R5: read back on the next edge
            chk("R2/R3/R4/R9 readback drive", {31'd0, rdata_drive}, 32'd1);
            chk("R2/R3/R4/R9 readback data", rdata, model[va]);
        end

        // R1: ce_c_n high blocks selection in flow mode
        cmd_load = 1'b1; addr = 8'd20; ce_c_n = 1'b1;
        tick();
        ce_c_n = 1'b0;
        chk("R1 ce_c_n inactive", {31'd0, rdata_drive}, 32'd0);
        // R7 flow: active read then deselect via ce_b
        cmd_load = 1'b1; addr = 8'd20;
        tick();
        cmd_load = 1'b1; ce_b = 1'b0;
        tick();
        ce_b = 1'b1; quiet_cmd();
        chk("R7 flow deselect", {31'd0, rdata_drive}, 32'd0);

        // R6: pipelined latency
        pipe_mode = 1'b1;
        cmd_load = 1'b1; addr = 8'd20;
        tick();
        quiet_cmd();
        chk("R6 not yet driven", {31'd0, rdata_drive}, 32'd0);
        tick();
        chk("R6 pipelined drive", {31'd0, rdata_drive}, 32'd1);
        chk("R6 pipelined data", rdata, model[20]);
        // R7 pipelined: deselect overrides the arriving read
        cmd_load = 1'b1; addr = 8'd10;
        tick();
        deselect();
        chk("R7 pipelined deselect", {31'd0, rdata_drive}, 32'd0);
        pipe_mode = 1'b0;

        // R8: interleaved burst from 33
        wr_full(8'd32, 32'hC0000020);
        wr_full(8'd33, 32'hC0000021);
        wr_full(8'd34, 32'hC0000022);
        wr_full(8'd35, 32'hC0000023);
        cmd_load = 1'b1; addr = 8'd33;
        tick();
        quiet_cmd();
        chk("R8 burst beat 0", rdata, model[33]);
        cmd_adv = 1'b1; tick();
        chk("R8 burst beat 1", rdata, model[32]);
        cmd_adv = 1'b0; tick();
        chk("R8 hold repeats", rdata, model[32]);
        cmd_adv = 1'b1; tick();
        chk("R8 burst beat 2", rdata, model[35]);
        tick();
        chk("R8 burst beat 3", rdata, model[34]);
        tick();
        chk("R8 burst wraps", rdata, model[33]);
        cmd_adv = 1'b0;

        // R10: asynchronous output enable
        #1 out_en = 1'b0;
        #0.5;
        chk("R10 oe low drive", {31'd0, rdata_drive}, 32'd0);
        chk("R10 oe low data", rdata, 32'd0);
        out_en = 1'b1;
        #0.5;
        chk("R10 oe restored", {31'd0, rdata_drive}, 32'd1);
        tick();

        // R11: sleep blocks a write and turns the output off
        sleep = 1'b1; cmd_load = 1'b1; addr = 8'd32; wdata = 32'h0BADF00D; all_wr = 1'b1;
        tick();
        chk("R11 sleep no drive", {31'd0, rdata_drive}, 32'd0);
        quiet_cmd(); sleep = 1'b0;
        tick();
        chk("R11 burst ended by sleep", {31'd0, rdata_drive}, 32'd0);
        cmd_load = 1'b1; addr = 8'd32;
        tick();
        quiet_cmd();
        chk("R11 contents kept", rdata, model[32]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule